// File: doc/BRIEF.md
# Programmable Duty Clock Divider

This block derives a slower clock from a fast input clock. The high phase and the low phase of the output are each set by their own count of input cycles, so the duty cycle and the divide ratio can be chosen freely. A half-cycle adjust bit lengthens the high phase by half an input period and shortens the low phase by the same amount. With this adjust, odd divide ratios can still produce a 50% duty cycle. A bypass bit routes the input clock straight to the output. An enable bit holds the output low. A start delay postpones the first rising edge after the divider starts from a stopped state.

A one-cycle load strobe writes a full set of fields into a holding stage. The held set takes effect at once if the divider is stopped or in bypass. If the divider is running, the held set waits until the low phase of the current output period has finished. As a result, a change of settings never cuts a pulse short.

Top module: `duty_clk_divider`

## Requirements
- R1: While reset is asserted, and after it is released until the first load, the output stays low, and a load strobe seen during reset has no effect.
- R2: The high phase lasts the high count in input cycles. A high count of 0 means 64 cycles.
- R3: The low phase lasts the low count in input cycles. A low count of 0 means 64 cycles. The output period is high count plus low count cycles.
- R4: With the adjust bit set, the output stays high for the first half of the first low-phase cycle and falls on the falling input edge. The high time is then high count plus one half cycle, and the low time is low count minus one half cycle.
- R5: When enabled with bypass set, the output equals the input clock: it is high in the first half of each input cycle and low in the second half.
- R6: With the enable bit clear, the output is held low, whether bypass is set or not.
- R7: Suppose a load strobe is sampled at rising edge t while the divider is stopped, and it starts the divider with delay D (0 to 63). Then the output first rises at rising edge t+1+D. A delay of 0 means no delay.
- R8: Suppose a load strobe is sampled while the divider is running. The new settings apply at the first period boundary after that sample: the rising edge that would begin the next high phase. If the new settings keep the divider running, the new high phase begins on that edge with no start delay. If they disable the divider, the output goes low there. If they select bypass, the input clock appears there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | One-cycle strobe that captures the configuration fields |
| hi_cnt | input | 6 | High-phase length in input cycles (0 means 64) |
| lo_cnt | input | 6 | Low-phase length in input cycles (0 means 64) |
| half_adj | input | 1 | Moves the falling output edge half an input cycle later |
| bypass | input | 1 | Routes the input clock to the output |
| enable | input | 1 | Runs the divider; when clear the output is low |
| start_dly | input | 6 | Input cycles to wait before the first high phase after a start |
| clk_out | output | 1 | Divided clock |

## Verification
The assertions assume that reset is released away from a rising clock edge. They also assume that every configuration input and the load strobe change only between rising edges, so the registers never sample a moving value. The stimulus meets this by changing every input at falling edges, or seven nanoseconds after a rising edge. It holds the strobe for exactly one rising edge, and it releases reset at a falling edge. Output samples are taken two nanoseconds after each rising edge and two nanoseconds after each falling edge. Each half of an input cycle is therefore read once, after both flops have settled.

// File: rtl/duty_clk_divider.sv
module duty_clk_divider #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] hi_cnt,
  input  logic [CW-1:0] lo_cnt,
  input  logic          half_adj,
  input  logic          bypass,
  input  logic          enable,
  input  logic [CW-1:0] start_dly,
  output logic          clk_out
);

  typedef enum logic [1:0] {ST_IDLE, ST_DLY, ST_HI, ST_LO} st_t;

  st_t           st;
  logic [CW-1:0] cnt;

  logic [CW-1:0] sh_hi, sh_lo, sh_dly;
  logic          sh_adj, sh_byp, sh_en, pending;

  logic [CW-1:0] c_hi, c_lo;
  logic          c_adj, c_byp, c_en;

  logic          q_neg;

  wire boundary = (st == ST_LO) && (cnt == '0);
  wire apply    = pending && ((st == ST_IDLE) || boundary);
  wire hi_ph    = (st == ST_HI);
  wire start    = sh_en && !sh_byp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_hi   <= '0;
      sh_lo   <= '0;
      sh_dly  <= '0;
      sh_adj  <= 1'b0;
      sh_byp  <= 1'b0;
      sh_en   <= 1'b0;
      pending <= 1'b0;
    end else if (load) begin
      sh_hi   <= hi_cnt;
      sh_lo   <= lo_cnt;
      sh_dly  <= start_dly;
      sh_adj  <= half_adj;
      sh_byp  <= bypass;
      sh_en   <= enable;
      pending <= 1'b1;
    end else if (apply) begin
      pending <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      c_hi  <= '0;
      c_lo  <= '0;
      c_adj <= 1'b0;
      c_byp <= 1'b0;
      c_en  <= 1'b0;
    end else if (apply) begin
      c_hi  <= sh_hi;
      c_lo  <= sh_lo;
      c_adj <= sh_adj;
      c_byp <= sh_byp;
      c_en  <= sh_en;
      if (!start) begin
        st <= ST_IDLE;
      end else if ((st == ST_IDLE) && (sh_dly != '0)) begin
        st  <= ST_DLY;
        cnt <= sh_dly - 1'b1;
      end else begin
        st  <= ST_HI;
        cnt <= sh_hi - 1'b1;
      end
    end else begin
      case (st)
        ST_DLY, ST_LO:
          if (cnt == '0) begin
            st  <= ST_HI;
            cnt <= c_hi - 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        ST_HI:
          if (cnt == '0) begin
            st  <= ST_LO;
            cnt <= c_lo - 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        default: ;
      endcase
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) q_neg <= 1'b0;
    else        q_neg <= hi_ph;
  end

  assign clk_out = c_en & (c_byp ? clk : (hi_ph | (c_adj & q_neg)));

  // R2
  hi_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HI && cnt != '0) |=> (st == ST_HI && cnt == CW'($past(cnt) - 1'b1)));

  // R3
  lo_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LO && cnt != '0) |=> (st == ST_LO && cnt == CW'($past(cnt) - 1'b1)));

  // R4
  half_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_neg == hi_ph);

  // R7
  dly_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DLY && cnt == '0) |=> (st == ST_HI));

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE && !(st == ST_LO && cnt == '0)) |=> $stable({c_hi, c_lo, c_adj, c_byp, c_en}));

  // R8
  pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && st == ST_HI) |=> pending);

endmodule

// File: tb/tb_duty_clk_divider.sv
module tb_duty_clk_divider;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0;
  logic [5:0] hi_cnt = '0, lo_cnt = '0, start_dly = '0;
  logic half_adj = 1'b0, bypass = 1'b0, enable = 1'b0;
  logic clk_out;

  int checks = 0;
  int errors = 0;
  int c1[6];
  int c2[6];
  int sw;

  always #5 clk = ~clk;

  duty_clk_divider #(.CW(6)) dut (
    .clk(clk), .rst_n(rst_n), .load(load), .hi_cnt(hi_cnt), .lo_cnt(lo_cnt),
    .half_adj(half_adj), .bypass(bypass), .enable(enable), .start_dly(start_dly),
    .clk_out(clk_out)
  );

  function automatic int hv(input int v);
    return (v == 0) ? 64 : v;
  endfunction

  // config layout: {high, low, adjust, bypass, enable, delay}
  function automatic bit cfgv(input int c[6], input int r, input bit b);
    int m;
    if (c[4] == 0) return 1'b0;
    if (c[3] != 0) return !b;
    if (r < 0) return 1'b0;
    m = r % (hv(c[0]) + hv(c[1]));
    if (!b) return (m < hv(c[0])) || (c[2] != 0 && m == hv(c[0]));
    return m < hv(c[0]);
  endfunction

  function automatic bit expv(input int n, input bit b);
    if (n >= sw) return cfgv(c2, n - sw, b);
    return cfgv(c1, n - c1[5], b);
  endfunction

  task automatic drive(input int c[6]);
    hi_cnt    = 6'(c[0]);
    lo_cnt    = 6'(c[1]);
    half_adj  = c[2] != 0;
    bypass    = c[3] != 0;
    enable    = c[4] != 0;
    start_dly = 6'(c[5]);
  endtask

  task automatic run(input int a[6], input int nl, input int b[6], input int ncyc, input string req);
    bit bad;
    bit got;
    int bn, bh;
    bit be;
    c1 = a;
    c2 = b;
    if (nl >= 0) sw = ((nl - a[5]) / (hv(a[0]) + hv(a[1])) + 1) * (hv(a[0]) + hv(a[1])) + a[5];
    else sw = 1 << 30;
    bad = 1'b0; bn = 0; bh = 0; be = 1'b0; got = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    drive(a);
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    for (int n = 0; n < ncyc; n++) begin
      @(posedge clk);
      #2;
      if (clk_out !== expv(n, 1'b0) && !bad) begin
        bad = 1'b1; bn = n; bh = 0; got = clk_out; be = expv(n, 1'b0);
      end
      #5;
      if (clk_out !== expv(n, 1'b1) && !bad) begin
        bad = 1'b1; bn = n; bh = 1; got = clk_out; be = expv(n, 1'b1);
      end
      if (n == nl - 1) begin
        drive(b);
        load = 1'b1;
      end
      if (n == nl) load = 1'b0;
    end
    checks++;
    if (bad) begin
      errors++;
      $display("FAIL %s h=%0d l=%0d adj=%0d byp=%0d en=%0d dly=%0d cycle=%0d half=%0d actual=%b expected=%b",
               req, a[0], a[1], a[2], a[3], a[4], a[5], bn, bh, got, be);
    end
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit bad;
    int nop[6];
    nop = '{1, 1, 0, 0, 0, 0};

    // R1: reset state, load during reset ignored
    bad = 1'b0;
    drive('{2, 2, 0, 1, 1, 0});
    load = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #2; if (clk_out !== 1'b0) bad = 1'b1;
      #5; if (clk_out !== 1'b0) bad = 1'b1;
    end
    load = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); #2; if (clk_out !== 1'b0) bad = 1'b1;
      #5; if (clk_out !== 1'b0) bad = 1'b1;
    end
    checks++;
    if (bad) begin
      errors++;
      $display("FAIL R1 reset output actual=1 expected=0");
    end

    // R2 R3 R4 R7: sweep of small counts, adjust and delay
    for (int h = 1; h <= 4; h++)
      for (int l = 1; l <= 4; l++)
        for (int e = 0; e <= 1; e++)
          for (int d = 0; d <= 2; d += 2)
            run('{h, l, e, 0, 1, d}, -1, nop, d + 2 * (h + l) + 4, "R2/R3/R4/R7");

    // R2 R3: zero count means 64
    run('{0, 1, 0, 0, 1, 0}, -1, nop, 2 * 65 + 4, "R2");
    run('{2, 0, 1, 0, 1, 0}, -1, nop, 2 * 66 + 4, "R3");
    // R7: largest delay
    run('{2, 2, 0, 0, 1, 63}, -1, nop, 63 + 12, "R7");
    // R5: bypass
    run('{3, 2, 1, 1, 1, 7}, -1, nop, 12, "R5");
    // R6: disabled, with and without bypass
    run('{2, 3, 1, 0, 0, 0}, -1, nop, 16, "R6");
    run('{2, 3, 0, 1, 0, 0}, -1, nop, 16, "R6");
    // R8: reload while running, at several points of the period
    run('{3, 2, 0, 0, 1, 0}, 6, '{1, 2, 1, 0, 1, 5}, 30, "R8");
    run('{3, 2, 0, 0, 1, 0}, 5, '{2, 1, 0, 0, 1, 0}, 30, "R8");
    run('{3, 2, 1, 0, 1, 0}, 9, '{4, 4, 0, 0, 1, 3}, 40, "R8");
    run('{2, 3, 0, 0, 1, 0}, 1, '{1, 1, 0, 0, 0, 0}, 24, "R8");
    run('{2, 3, 1, 0, 1, 0}, 7, '{1, 1, 0, 1, 1, 0}, 24, "R8");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule